// File: doc/BRIEF.md
# SPI Slave Shift Engine with Ready Handshake

This block is a serial-peripheral slave that shifts one word in on MOSI and one word out on MISO per transfer. It also drives an active-low ready line back to the master. Local logic writes a transmit word through a parallel port. The ready line then goes low to tell the master that fresh data is waiting. The master clocks the word across. Once the final bit has arrived, the ready line returns high, and the received word appears on a parallel port together with a one-cycle valid strobe.

The block has two wiring modes. In four-wire mode there is no chip select, so the slave alone decides when ready falls and rises. In five-wire mode a chip select input must also be low before ready can fall, and MISO is released whenever the select is high. When ready is inactive it is either driven high or released to high impedance, so that an external pull resistor sets the line level.

The serial clock, MOSI and chip select are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. Data moves MSB first. MOSI is sampled on rising serial-clock edges, and MISO advances after falling edges.

Top module: `spi_hs_slave`

## Requirements
- R1: After reset, rdy_n is 1 with rdy_oe 1 (when cfg_idle_float is 0), rx_valid is 0 and no ready handshake is pending.
- R2: In four-wire mode (cfg_five_wire = 0), a tx_wr pulse while idle drives rdy_n to 0 in the first system clock after the write edge, with cs_n ignored.
- R3: In five-wire mode (cfg_five_wire = 1), rdy_n is 0 only while a written word is loaded and the synchronized cs_n is 0; while cs_n is 1 it stays 1.
- R4: rdy_n returns to 1 in the same cycle that rx_valid is 1, once the W-th rising serial-clock edge of the word has been sampled.
- R5: rx_data holds the W bits sampled on MOSI at rising serial-clock edges, with the first bit in bit W-1, and rx_valid is a pulse exactly one system clock long.
- R6: MISO shows tx_data bit W-1 from the load onward and moves to the next lower bit after each falling serial-clock edge that follows a sampled bit.
- R7: With cfg_idle_float = 1, rdy_oe is 0 whenever rdy_n is inactive. With cfg_idle_float = 0, rdy_oe stays 1. rdy_oe is always 1 while rdy_n is 0.
- R8: A tx_wr that arrives while a word is loaded is held, with the latest write kept. At completion rdy_n goes high for one cycle, then falls again with the held word loaded.
- R9: In five-wire mode miso_oe is 0 while the synchronized cs_n is 1. In four-wire mode miso_oe is always 1.
- R10: In five-wire mode, serial-clock edges that occur while cs_n is 1 neither count bits nor shift data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_five_wire | input | 1 | 1 selects five-wire mode with chip select gating |
| cfg_idle_float | input | 1 | 1 releases the inactive ready line to high impedance |
| tx_wr | input | 1 | One-cycle write strobe for tx_data |
| tx_data | input | W | Word to transmit |
| rx_data | output | W | Last received word |
| rx_valid | output | 1 | One-cycle strobe, rx_data updated |
| sclk | input | 1 | Serial clock from master (idle low) |
| mosi | input | 1 | Serial data from master |
| cs_n | input | 1 | Active-low chip select (five-wire mode only) |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso |
| rdy_n | output | 1 | Active-low ready handshake value |
| rdy_oe | output | 1 | Output enable for rdy_n |

## Verification
In four-wire mode rdy_n falls one system clock after a write edge. In five-wire mode it falls two clocks after cs_n falls, because of the synchronizer. rx_valid and the rise of rdy_n come three system clocks after the last rising serial-clock edge at the pins. MISO moves three clocks after each falling edge. The bench runs each serial half-period for four system clocks, drives and samples only on falling system-clock edges, and reads MISO just before it raises the serial clock. A falling-edge monitor records rx_data and rdy_n in the one cycle that rx_valid is high. Each check of a level is made only after a margin longer than these latencies.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_ARMED = 2'd1,
    HS_DONE  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/spi_hs_sync.sv
// Reset synchronizer plus two-flop synchronizers for the serial pins,
// with edge detection on one chosen bit.
module spi_hs_sync #(
  parameter int unsigned     NSIG     = 3,
  parameter int unsigned     EDGE_BIT = 0,
  parameter logic [NSIG-1:0] RST_VAL  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] async_i,
  output logic            rst_ni,
  output logic [NSIG-1:0] sync_o,
  output logic            rise_o,
  output logic            fall_o
);
  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

  logic prev_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL[EDGE_BIT];
    else         prev_q <= sync_o[EDGE_BIT];
  end

  assign rise_o = sync_o[EDGE_BIT] & ~prev_q;
  assign fall_o = ~sync_o[EDGE_BIT] & prev_q;
endmodule

// File: rtl/spi_hs_shift.sv
// Transmit and receive shift registers with bit counter, MSB first.
module spi_hs_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_word_i,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  output logic         miso_o,
  output logic         done_o,
  output logic [W-1:0] rx_word_o
);
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  tx_q, tx_d;
  logic [W-1:0]  rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    if (load_i) begin
      tx_d  = load_word_i;
      cnt_d = '0;
    end else if (active_i) begin
      if (rise_i) begin
        rx_d  = {rx_q[W-2:0], mosi_i};
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end else if (fall_i && (cnt_q != '0)) begin
        tx_d = {tx_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
    end
  end

  assign miso_o    = tx_q[W-1];
  assign done_o    = active_i & rise_i & ~load_i & (cnt_q == LAST);
  assign rx_word_o = {rx_q[W-2:0], mosi_i};
endmodule

// File: rtl/spi_hs_ctrl.sv
// Handshake state machine, pending write buffer and RX holding register.
module spi_hs_ctrl
  import spi_hs_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_wr_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         done_i,
  input  logic [W-1:0] rx_word_i,
  output logic         load_o,
  output logic [W-1:0] load_word_o,
  output logic         armed_o,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_data_o
);
  hs_state_e    st_q, st_d;
  logic         pv_q, pv_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] hold_q;
  logic         hold_en;

  always_comb begin
    st_d        = st_q;
    pv_d        = pv_q;
    pend_d      = pend_q;
    load_o      = 1'b0;
    load_word_o = tx_data_i;
    hold_en     = 1'b0;
    unique case (st_q)
      HS_IDLE: begin
        if (tx_wr_i) begin
          load_o = 1'b1;
          st_d   = HS_ARMED;
        end
      end
      HS_ARMED: begin
        if (tx_wr_i) begin
          pv_d   = 1'b1;
          pend_d = tx_data_i;
        end
        if (done_i) begin
          hold_en = 1'b1;
          st_d    = HS_DONE;
        end
      end
      HS_DONE: begin
        if (tx_wr_i) begin
          load_o = 1'b1;
          pv_d   = 1'b0;
          st_d   = HS_ARMED;
        end else if (pv_q) begin
          load_o      = 1'b1;
          load_word_o = pend_q;
          pv_d        = 1'b0;
          st_d        = HS_ARMED;
        end else begin
          st_d = HS_IDLE;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      pv_q   <= 1'b0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pv_q   <= pv_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= rx_word_i;
  end

  assign armed_o    = (st_q == HS_ARMED);
  assign rx_valid_o = (st_q == HS_DONE);
  assign rx_data_o  = hold_q;
endmodule

// File: rtl/spi_hs_slave.sv
module spi_hs_slave #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_five_wire,
  input  logic         cfg_idle_float,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_data,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         sclk,
  input  logic         mosi,
  input  logic         cs_n,
  output logic         miso,
  output logic         miso_oe,
  output logic         rdy_n,
  output logic         rdy_oe
);
  logic         rst_ni;
  logic [2:0]   pins_s;
  logic         sclk_rise, sclk_fall;
  logic         mosi_s, cs_s;
  logic         selected, armed, active;
  logic         load, done;
  logic [W-1:0] load_word, rx_word;

  spi_hs_sync #(.NSIG(3), .EDGE_BIT(0), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_n, mosi, sclk}),
    .rst_ni  (rst_ni),
    .sync_o  (pins_s),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  assign mosi_s   = pins_s[1];
  assign cs_s     = pins_s[2];
  assign selected = ~cfg_five_wire | ~cs_s;
  assign active   = armed & selected;

  spi_hs_shift #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_ni),
    .load_i      (load),
    .load_word_i (load_word),
    .active_i    (active),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .mosi_i      (mosi_s),
    .miso_o      (miso),
    .done_o      (done),
    .rx_word_o   (rx_word)
  );

  spi_hs_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ni),
    .tx_wr_i     (tx_wr),
    .tx_data_i   (tx_data),
    .done_i      (done),
    .rx_word_i   (rx_word),
    .load_o      (load),
    .load_word_o (load_word),
    .armed_o     (armed),
    .rx_valid_o  (rx_valid),
    .rx_data_o   (rx_data)
  );

  assign rdy_n   = ~active;
  assign rdy_oe  = active | ~cfg_idle_float;
  assign miso_oe = selected;
endmodule

// File: rtl/spi_hs_chk.sv
module spi_hs_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_five_wire,
  input logic cfg_idle_float,
  input logic cs_s,
  input logic rx_valid,
  input logic rdy_n,
  input logic rdy_oe,
  input logic miso_oe
);
  // R4
  rdy_high_at_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rdy_n);
  // R5
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7
  oe_while_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> rdy_oe);
  // R7
  float_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idle_float && rdy_n) |-> !rdy_oe);
  // R7
  driven_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_idle_float |-> rdy_oe);
  // R3
  no_ready_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_five_wire && cs_s) |-> rdy_n);
  // R9
  miso_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_five_wire && cs_s) |-> !miso_oe);
endmodule

bind spi_hs_slave spi_hs_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_five_wire  (cfg_five_wire),
  .cfg_idle_float (cfg_idle_float),
  .cs_s           (cs_s),
  .rx_valid       (rx_valid),
  .rdy_n          (rdy_n),
  .rdy_oe         (rdy_oe),
  .miso_oe        (miso_oe)
);

// File: tb/spi_hs_slave_tb.sv
module spi_hs_slave_tb;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int HALF  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_five_wire = 1'b0, cfg_idle_float = 1'b0;
  logic         tx_wr = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic         sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic         miso, miso_oe, rdy_n, rdy_oe;

  int tests = 0, fails = 0;
  int vcnt = 0;
  logic [W-1:0] rx_got = '0;
  logic         rdy_at_valid = 1'b0;
  logic [W-1:0] miso_got;

  always #(CLK_P/2) clk = ~clk;

  spi_hs_slave #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_five_wire(cfg_five_wire),
    .cfg_idle_float(cfg_idle_float), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe), .rdy_n(rdy_n), .rdy_oe(rdy_oe)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt++;
      rx_got       = rx_data;
      rdy_at_valid = rdy_n;
    end
  end

  function automatic logic exp_oe(input logic ready, input logic flt);
    return ready | ~flt;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_tx(input logic [W-1:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  // Mode-0 master: drive MOSI, sample MISO, raise and lower the clock.
  task automatic xfer(input logic [W-1:0] mw, output logic [W-1:0] sw);
    for (int i = W - 1; i >= 0; i--) begin
      mosi = mw[i];
      wait_clk(HALF);
      sw[i] = miso;
      sclk  = 1'b1;
      wait_clk(HALF);
      sclk  = 1'b0;
    end
    wait_clk(HALF + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v0;
    void'($urandom(32'h5a17));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    check("R1 rdy_n", rdy_n, 1);
    check("R1 rdy_oe", rdy_oe, exp_oe(0, 0));
    check("R1 rx_valid", rx_valid, 0);

    // R2, R6, R5, R4 four-wire directed, cs_n held high to show it is ignored
    write_tx(16'hA55A);
    check("R2 rdy_n low after write", rdy_n, 0);
    check("R6 first MISO bit", miso, 1);
    v0 = vcnt;
    xfer(16'h1234, miso_got);
    check("R5 rx word", rx_got, 16'h1234);
    check("R5 one valid pulse", vcnt - v0, 1);
    check("R6 miso word", miso_got, 16'hA55A);
    check("R4 rdy high at valid", rdy_at_valid, 1);
    check("R4 rdy high after word", rdy_n, 1);
    check("R9 four-wire miso_oe", miso_oe, 1);

    // R7 floating idle level
    cfg_idle_float = 1'b1;
    wait_clk(1);
    check("R7 idle released", rdy_oe, exp_oe(0, 1));
    write_tx(16'h0F0F);
    check("R7 driven while ready", rdy_oe, exp_oe(1, 1));
    xfer(16'hFFFF, miso_got);
    check("R7 released after word", rdy_oe, exp_oe(0, 1));
    check("R6 word in float mode", miso_got, 16'h0F0F);
    cfg_idle_float = 1'b0;

    // R8 pending write
    write_tx(16'h1111);
    write_tx(16'h2222);
    write_tx(16'h3333);
    xfer(16'hC3C3, miso_got);
    check("R8 first word sent", miso_got, 16'h1111);
    check("R8 rdy high for one cycle at end", rdy_at_valid, 1);
    check("R8 ready again with held word", rdy_n, 0);
    xfer(16'h3C3C, miso_got);
    check("R8 latest held word sent", miso_got, 16'h3333);
    check("R8 idle after held word", rdy_n, 1);

    // R3, R9, R10 five-wire
    cfg_five_wire = 1'b1;
    cs_n = 1'b1;
    wait_clk(3);
    check("R9 miso released unselected", miso_oe, 0);
    write_tx(16'hBEEF);
    wait_clk(2);
    check("R3 no ready while unselected", rdy_n, 1);
    v0 = vcnt;
    for (int i = 0; i < W; i++) begin
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
    check("R10 no word while unselected", vcnt - v0, 0);
    check("R10 still armed unselected", rdy_n, 1);
    cs_n = 1'b0;
    wait_clk(3);
    check("R3 ready once selected", rdy_n, 0);
    check("R9 miso driven selected", miso_oe, 1);
    xfer(16'h6789, miso_got);
    check("R10 tx intact after ignored clocks", miso_got, 16'hBEEF);
    check("R10 rx word five-wire", rx_got, 16'h6789);
    check("R4 five-wire rdy high", rdy_n, 1);
    cs_n = 1'b1;
    wait_clk(3);

    // random transfers in both modes
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] tw, mw;
      logic five;
      tw   = W'($urandom);
      mw   = W'($urandom);
      five = 1'($urandom);
      cfg_five_wire = five;
      cfg_idle_float = 1'($urandom);
      cs_n = five ? 1'b0 : 1'($urandom);
      wait_clk(3);
      write_tx(tw);
      check("R2 R3 ready random", rdy_n, 0);
      check("R7 oe ready random", rdy_oe, 1);
      v0 = vcnt;
      xfer(mw, miso_got);
      check("R5 rx random", rx_got, mw);
      check("R6 tx random", miso_got, tw);
      check("R5 pulse random", vcnt - v0, 1);
      check("R4 rdy random", rdy_at_valid, 1);
      check("R7 oe idle random", rdy_oe, exp_oe(0, cfg_idle_float));
      cs_n = 1'b1;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule